// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog timer that software controls through a small byte-addressed register window. It counts down in two stages, one after the other. When the first stage runs out, the block raises a timeout flag that software can see, and the second stage starts. When the second stage runs out, the block can request a warm or a cold system reset, and it can toggle an output pin. Software keeps the timer alive by writing a reload bit. This restarts the first stage from its preload.

The preload registers and the reload register are guarded by a key. Software first writes two fixed bytes, in order, to the key offset. This opens the key for exactly one guarded write. A lock bit, once set, freezes the enable and all configuration until reset. Reloading stays possible after locking, so software can still keep the timer alive. With the prescaler on, a preload value fills the upper bits of a wide down counter, so one preload unit equals 2^PRE_SHIFT clock cycles. With the default PRE_SHIFT of 15 and a 33 MHz clock, a 20-bit preload covers timeouts from about 1 ms up to well beyond 600 s. The bus bridge and the system reset logic sit outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, every register reads 0 and tout_flag, rst_warm, rst_cold and wd_pin are low.
- R2: A write to a preload (offset 0x00 stage one, 0x04 stage two) or to the reload byte (offset 0x0D) takes effect only if the two writes just before it were byte 0x80 and then byte 0x86 to the key offset 0x0C. Otherwise the write is ignored.
- R3: A write to any other offset between the two key bytes, or a second key byte other than 0x86, returns the key to idle. The guarded write that follows is then ignored.
- R4: Any write made while the key is open closes the key, so a second guarded write needs a new key sequence.
- R5: A stage lasts preload+1 cycles when control bit 2 (0x04) is clear, and (preload+1)*2^PRE_SHIFT cycles when it is set. Counting starts at the clock edge that writes the enable bit.
- R6: When stage one expires, tout_flag is set (it also reads back as bit 1 of offset 0x0D) and stage two starts from the stage-two preload.
- R7: When stage two expires and control bit 4 (0x10) is set, the block raises rst_warm if control bit 3 (0x08) is set, and rst_cold if it is clear. The request holds until reset, and the two outputs are never high together. With bit 4 clear, neither output rises.
- R8: Each stage-two expiry toggles wd_pin unless control bit 5 (0x20) is set. The next stage one then starts by itself.
- R9: A keyed write to offset 0x0D with bit 0 set restarts stage one from its preload. Bit 1 clears tout_flag. Both bits may be set in the same write.
- R10: At offset 0x18, bit 1 is the enable and bit 0 the lock. Once the lock is set, writes to 0x18, to the control register at 0x10 and to both preloads are ignored until reset, while reload and flag clear still work.
- R11: While the enable is clear, the counter holds the stage-one preload and nothing expires.
- R12: Offset 0x14 reads the stage in bit 31 (1 for stage two) and the remaining preload units in bits 19:0. The control register at 0x10 reads back only bits 5:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | DW | Write data; byte registers use bits 7:0 |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | DW | Read data, combinational from rd_addr |
| tout_flag | output | 1 | Stage-one timeout flag |
| rst_warm | output | 1 | Sticky warm reset request |
| rst_cold | output | 1 | Sticky cold reset request |
| wd_pin | output | 1 | Output pin toggled on each stage-two expiry |

## Verification
If the key sequencer is in the wrong state, the next write to a preload shows it at once: the value read back is either missing or accepted when it should not be. A counter that is off by a cycle, or loaded from the wrong slice, moves the rise of tout_flag by one or more clock edges. The bench samples exactly at the expected edge and one edge before it, so a shift of even one cycle is reported. A wrong stage or lock state shows up within one read of offsets 0x14 or 0x18, or at the stage-two expiry through rst_warm, rst_cold and wd_pin.

// File: rtl/kwd_pkg.sv
// Shared offsets, key bytes and key-state type for the keyed watchdog.
// Assumes byte offsets on a 5-bit address; register layout is fixed here.
package kwd_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_PV1 = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PV2 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_KEY = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RLD = 5'h0D;
    localparam logic [ADDR_W-1:0] OFS_CTL = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STS = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_LCK = 5'h18;
    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;
    typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_OPEN} key_state_t;
endpackage

// File: rtl/kwd_keyseq.sv
// Key sequencer: two ordered bytes to the key offset open the key for
// exactly one following write. Any other write closes it again.
// Assumes at most one write per cycle.
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    output logic              key_open
);
    key_state_t ks_q;
    logic       at_key;

    // Decode whether the current write targets the key offset
    assign at_key = (wr_addr == OFS_KEY);

    // Advance the key state on every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_q <= KS_IDLE;
        end else if (wr_en) begin
            unique case (ks_q)
                KS_IDLE: ks_q <= (at_key && wr_byte == KEY_FIRST)  ? KS_HALF : KS_IDLE;
                KS_HALF: ks_q <= (at_key && wr_byte == KEY_SECOND) ? KS_OPEN : KS_IDLE;
                default: ks_q <= KS_IDLE;
            endcase
        end
    end

    // Key is usable only in the open state
    assign key_open = (ks_q == KS_OPEN);
endmodule

// File: rtl/kwd_downcnt.sv
// Two-stage down counter. With the prescaler on, a preload fills the upper
// PV_W bits of a PV_W+PRE_SHIFT counter with ones below, so a stage lasts
// (pv+1)*2^PRE_SHIFT cycles; without it a stage lasts pv+1 cycles.
// Assumes PRE_SHIFT >= 1 and PRE_SHIFT <= PV_W.
module kwd_downcnt #(
    parameter int PV_W      = 20,
    parameter int PRE_SHIFT = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            kick,
    input  logic            presc,
    input  logic [PV_W-1:0] pv_a,
    input  logic [PV_W-1:0] pv_b,
    output logic [PV_W-1:0] units,
    output logic            in_b,
    output logic            exp_a,
    output logic            exp_b
);
    localparam int CW = PV_W + PRE_SHIFT;

    logic [CW-1:0] cnt_q;
    logic          stg_q;
    logic          at_zero;

    // Counter image of a preload for the current prescale mode
    function automatic logic [CW-1:0] span(input logic [PV_W-1:0] pv, input logic p);
        span = p ? {pv, {PRE_SHIFT{1'b1}}} : {{PRE_SHIFT{1'b0}}, pv};
    endfunction

    // Expiry strobes for the running stage
    always_comb begin
        at_zero = (cnt_q == '0);
        exp_a   = run && !kick && at_zero && !stg_q;
        exp_b   = run && !kick && at_zero &&  stg_q;
    end

    // Load, chain stages or count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            stg_q <= 1'b0;
        end else if (!run || kick) begin
            cnt_q <= span(pv_a, presc);
            stg_q <= 1'b0;
        end else if (at_zero) begin
            cnt_q <= stg_q ? span(pv_a, presc) : span(pv_b, presc);
            stg_q <= ~stg_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Remaining whole units and current stage
    assign units = presc ? cnt_q[CW-1:PRE_SHIFT] : cnt_q[PV_W-1:0];
    assign in_b  = stg_q;
endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed two-stage watchdog: register file, write gating by key
// and lock, timeout flag and reset-request outputs.
// Assumes DW > PV_W and one register write per cycle; reads are combinational.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int DW        = 32,
    parameter int PV_W      = 20,
    parameter int PRE_SHIFT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              tout_flag,
    output logic              rst_warm,
    output logic              rst_cold,
    output logic              wd_pin
);
    logic [PV_W-1:0] pv1_q, pv2_q, units;
    logic            presc_q, warm_q, rsten_q, togdis_q;
    logic            en_q, lock_q;
    logic            key_open, stage2, exp1, exp2;
    logic            wr_pv1, wr_pv2, wr_rld, wr_ctl, wr_lck, kick, clr;
    logic [7:0]      wb;
    logic            unused_hi;

    assign wb        = wr_data[7:0];
    assign unused_hi = ^wr_data[DW-1:PV_W];

    kwd_keyseq u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_byte (wb),
        .key_open(key_open)
    );

    kwd_downcnt #(.PV_W(PV_W), .PRE_SHIFT(PRE_SHIFT)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en_q),
        .kick (kick),
        .presc(presc_q),
        .pv_a (pv1_q),
        .pv_b (pv2_q),
        .units(units),
        .in_b (stage2),
        .exp_a(exp1),
        .exp_b(exp2)
    );

    // Gate writes by key and lock
    always_comb begin
        wr_pv1 = wr_en && key_open && !lock_q && (wr_addr == OFS_PV1);
        wr_pv2 = wr_en && key_open && !lock_q && (wr_addr == OFS_PV2);
        wr_rld = wr_en && key_open && (wr_addr == OFS_RLD);
        wr_ctl = wr_en && !lock_q && (wr_addr == OFS_CTL);
        wr_lck = wr_en && !lock_q && (wr_addr == OFS_LCK);
        kick   = wr_rld && wb[0];
        clr    = wr_rld && wb[1];
    end

    // Configuration registers: preloads, control, enable and lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv1_q <= '0; pv2_q <= '0;
            presc_q <= 1'b0; warm_q <= 1'b0; rsten_q <= 1'b0; togdis_q <= 1'b0;
            en_q <= 1'b0; lock_q <= 1'b0;
        end else begin
            if (wr_pv1) pv1_q <= wr_data[PV_W-1:0];
            if (wr_pv2) pv2_q <= wr_data[PV_W-1:0];
            if (wr_ctl) begin
                presc_q  <= wb[2];
                warm_q   <= wb[3];
                rsten_q  <= wb[4];
                togdis_q <= wb[5];
            end
            if (wr_lck) begin
                en_q   <= wb[1];
                lock_q <= wb[0];
            end
        end
    end

    // Timeout flag: a stage-one expiry wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)    tout_flag <= 1'b0;
        else if (exp1) tout_flag <= 1'b1;
        else if (clr)  tout_flag <= 1'b0;
    end

    // Sticky reset request and pin toggle on stage-two expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_warm <= 1'b0;
            rst_cold <= 1'b0;
            wd_pin   <= 1'b0;
        end else if (exp2) begin
            if (rsten_q && !rst_warm && !rst_cold) begin
                rst_warm <= warm_q;
                rst_cold <= !warm_q;
            end
            if (!togdis_q) wd_pin <= ~wd_pin;
        end
    end

    // Register read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_PV1: rd_data[PV_W-1:0] = pv1_q;
            OFS_PV2: rd_data[PV_W-1:0] = pv2_q;
            OFS_RLD: rd_data[1]        = tout_flag;
            OFS_CTL: rd_data[5:2]      = {togdis_q, rsten_q, warm_q, presc_q};
            OFS_STS: begin
                rd_data[DW-1]      = stage2;
                rd_data[PV_W-1:0]  = units;
            end
            OFS_LCK: rd_data[1:0]      = {en_q, lock_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/kwd_chk.sv
// Property checker for keyed_watchdog, attached by bind below.
// Assumes it sees the top's internal enable, lock, key and stage signals.
module kwd_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic key_open,
    input logic en_q,
    input logic lock_q,
    input logic stage2,
    input logic tout_flag,
    input logic rst_warm,
    input logic rst_cold
);
    // R7
    reset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_warm && rst_cold));
    // R7
    warm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_warm |=> rst_warm);
    // R7
    cold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cold |=> rst_cold);
    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R10
    lock_en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(en_q));
    // R4
    key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_open && wr_en) |=> !key_open);
    // R11
    idle_no_tout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !tout_flag) |=> !tout_flag);
    // R6
    tout_enters_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_flag) |-> stage2);
endmodule

bind keyed_watchdog kwd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .key_open (key_open),
    .en_q     (en_q),
    .lock_q   (lock_q),
    .stage2   (stage2),
    .tout_flag(tout_flag),
    .rst_warm (rst_warm),
    .rst_cold (rst_cold)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
    import kwd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tout_flag, rst_warm, rst_cold, wd_pin;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    keyed_watchdog #(.DW(32), .PV_W(20), .PRE_SHIFT(3)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tout_flag(tout_flag), .rst_warm(rst_warm), .rst_cold(rst_cold),
        .wd_pin(wd_pin)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements): actual=%0d cycles expected<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [7:0]  req;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 5'h00, 32'h12,       5'h00, 32'h0},       // R2 no key
        '{8'd2, 5'h0C, 32'h80,       5'h00, 32'h0},
        '{8'd2, 5'h0C, 32'h86,       5'h00, 32'h0},
        '{8'd2, 5'h00, 32'h12,       5'h00, 32'h12},      // R2 keyed
        '{8'd4, 5'h04, 32'h34,       5'h04, 32'h0},       // R4 consumed
        '{8'd3, 5'h0C, 32'h80,       5'h04, 32'h0},
        '{8'd3, 5'h10, 32'h00,       5'h10, 32'h0},       // R3 interleaved
        '{8'd3, 5'h0C, 32'h86,       5'h04, 32'h0},
        '{8'd3, 5'h04, 32'h34,       5'h04, 32'h0},       // R3
        '{8'd3, 5'h0C, 32'h80,       5'h04, 32'h0},
        '{8'd3, 5'h0C, 32'h81,       5'h04, 32'h0},       // R3 wrong byte
        '{8'd3, 5'h04, 32'h34,       5'h04, 32'h0},
        '{8'd2, 5'h0C, 32'h80,       5'h04, 32'h0},
        '{8'd2, 5'h0C, 32'h86,       5'h04, 32'h0},
        '{8'd2, 5'h04, 32'hFFFFF123, 5'h04, 32'h000FF123}, // R2 width
        '{8'd12, 5'h10, 32'h3C,      5'h10, 32'h3C},      // R12
        '{8'd12, 5'h10, 32'hC3,      5'h10, 32'h00}       // R12
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key();
        wr(OFS_KEY, 32'h80);
        wr(OFS_KEY, 32'h86);
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        waitc(2);
        rst_n = 1'b1;
    endtask

    initial begin
        waitc(3);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1", OFS_PV1, 0); rdchk("R1", OFS_PV2, 0); rdchk("R1", OFS_CTL, 0);
        rdchk("R1", OFS_STS, 0); rdchk("R1", OFS_LCK, 0); rdchk("R1", OFS_RLD, 0);
        chk("R1", {28'b0, tout_flag, rst_warm, rst_cold, wd_pin}, 0);

        // Vector walk: key sequences and register write-back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rdchk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ra, VEC[i].ex);
        end

        // R5 R6 R7 R8 R12: unscaled timing, warm reset, toggle
        do_reset();
        key(); wr(OFS_PV1, 5);
        key(); wr(OFS_PV2, 3);
        wr(OFS_CTL, 32'h18);
        wr(OFS_LCK, 32'h2);
        rdchk("R12", OFS_STS, 32'h5);
        waitc(5); chk("R5", tout_flag, 0);
        waitc(1); chk("R6", tout_flag, 1);
        rdchk("R6", OFS_RLD, 32'h2);
        rdchk("R12", OFS_STS, 32'h80000003);
        waitc(3); chk("R7", rst_warm, 0);
        waitc(1); chk("R7", {rst_warm, rst_cold}, 2'b10);
        chk("R8", wd_pin, 1);
        rdchk("R8", OFS_STS, 32'h5);

        // R11: disabled counter holds
        do_reset();
        key(); wr(OFS_PV1, 2);
        waitc(20);
        chk("R11", tout_flag, 0);
        rdchk("R11", OFS_STS, 32'h2);

        // R5: prescaled timing, 2 units of 8 cycles
        do_reset();
        key(); wr(OFS_PV1, 1);
        wr(OFS_CTL, 32'h04);
        wr(OFS_LCK, 32'h2);
        rdchk("R5", OFS_STS, 32'h1);
        waitc(15); chk("R5", tout_flag, 0);
        waitc(1);  chk("R5", tout_flag, 1);
        rdchk("R5", OFS_STS, 32'h80000000);

        // R9: reload restarts stage one, clear flag, both bits
        do_reset();
        key(); wr(OFS_PV1, 5);
        key(); wr(OFS_PV2, 40);
        wr(OFS_LCK, 32'h2);
        waitc(2);
        key(); wr(OFS_RLD, 32'h1);
        rdchk("R9", OFS_STS, 32'h5);
        waitc(5); chk("R9", tout_flag, 0);
        waitc(1); chk("R9", tout_flag, 1);
        key(); wr(OFS_RLD, 32'h2);
        chk("R9", tout_flag, 0);
        rdchk("R9", OFS_STS, {1'b1, 31'd0} | 32'(40 - 3));
        key(); wr(OFS_RLD, 32'h3);
        chk("R9", tout_flag, 0);
        rdchk("R9", OFS_STS, 32'h5);

        // R7 R8: cold reset, toggle disabled, sticky over a second expiry
        do_reset();
        key(); wr(OFS_PV1, 1);
        key(); wr(OFS_PV2, 1);
        wr(OFS_CTL, 32'h30);
        wr(OFS_LCK, 32'h2);
        waitc(3); chk("R7", rst_cold, 0);
        waitc(1); chk("R7", {rst_warm, rst_cold}, 2'b01);
        chk("R8", wd_pin, 0);
        waitc(4); chk("R7", {rst_warm, rst_cold}, 2'b01);
        chk("R8", wd_pin, 0);

        // R7 R8: reset output disabled, pin toggles each stage-two expiry
        do_reset();
        key(); wr(OFS_PV1, 1);
        key(); wr(OFS_PV2, 1);
        wr(OFS_CTL, 32'h00);
        wr(OFS_LCK, 32'h2);
        waitc(4); chk("R8", wd_pin, 1);
        chk("R7", {rst_warm, rst_cold}, 2'b00);
        waitc(4); chk("R8", wd_pin, 0);

        // R10: lock freezes enable and configuration, reload still works
        do_reset();
        key(); wr(OFS_PV1, 5);
        key(); wr(OFS_PV2, 40);
        wr(OFS_LCK, 32'h3);
        wr(OFS_LCK, 32'h0);
        rdchk("R10", OFS_LCK, 32'h3);
        wr(OFS_CTL, 32'h3C);
        rdchk("R10", OFS_CTL, 32'h0);
        key(); wr(OFS_PV1, 9);
        rdchk("R10", OFS_PV1, 32'h5);
        waitc(1); chk("R10", tout_flag, 1);
        key(); wr(OFS_RLD, 32'h2);
        chk("R10", tout_flag, 0);
        rdchk("R10", OFS_LCK, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule